// File: doc/BRIEF.md
# Paged Program Counter Unit

This unit holds the fetch address of a small 8-bit microcontroller core and picks the next address every clock cycle. There are four sources. The first is a plain increment. The second is a write to the low byte of the counter. The third is a jump or call that carries an 11-bit immediate. The fourth is a return that supplies a complete 13-bit address. When no source is active, the counter holds its value.

A separate 8-bit page latch, with its own write and read ports, supplies the upper address bits. A low-byte write takes five latch bits and places them on the counter's upper byte. A jump takes only the two page bits. The upper counter bits are therefore never read directly: they are always loaded through the latch. The low byte is not a true adder, so a table offset added to it never carries into the upper bits. A computed jump past a 256-word boundary lands in the page that the latch selects.

The unit chooses its load source with an enumerated selector. The sources are `SRC_HOLD`, `SRC_INC`, `SRC_LOW`, `SRC_JUMP` and `SRC_RET`. The arbiter moves to one of them in each cycle under a fixed priority. The counter register then takes the value that the chosen source computes. The transitions, one per cycle, are:
- hold → hold when there is no strobe;
- any → inc on an increment;
- any → low on a low-byte write;
- any → jump on a jump or call;
- any → ret on a return.

Top module: `paged_pc`

## Requirements
- R1: While `rst_n` is low, and after it is released, `pc_out` is 0 and `latch_rdata` is 0. The reset is asynchronous.
- R2: If `inc_en` is the only strobe, `pc_out` becomes `(pc_out + 1) mod 8192` one cycle later. 0x1FFF therefore goes to 0x0000.
- R3: If `low_wr` is the highest active strobe, `pc_out` becomes `{latch[4:0], low_wdata[7:0]}` one cycle later. No carry from the low byte reaches bits 12:8.
- R4: If `jump_en` is the highest active strobe, `pc_out` becomes `{latch[4:3], jump_target[10:0]}` one cycle later.
- R5: If `ret_en` is asserted, `pc_out` becomes `ret_addr` one cycle later, and all 13 bits are loaded.
- R6: When strobes overlap, the one that wins is chosen in this order: `ret_en`, then `jump_en`, then `low_wr`, then `inc_en`.
- R7: `latch_wr` stores `latch_wdata` in the latch. The stored value appears on `latch_rdata` one cycle later. All 8 bits are stored, but bits 7:5 never affect the PC. The latch changes only through `latch_wr`.
- R8: If `latch_wr` is in the same cycle as a low-byte write or a jump, the PC load uses the latch value from before that write.
- R9: If no strobe is active, `pc_out` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| inc_en | input | 1 | Advance the PC by one |
| low_wr | input | 1 | Low-byte write strobe |
| low_wdata | input | 8 | Value written to the low byte |
| latch_wr | input | 1 | Page latch write strobe |
| latch_wdata | input | 8 | Value written to the page latch |
| latch_rdata | output | 8 | Current page latch contents |
| jump_en | input | 1 | Jump/call strobe |
| jump_target | input | 11 | Immediate target within the page |
| ret_en | input | 1 | Return-load strobe |
| ret_addr | input | 13 | Full return address |
| pc_out | output | 13 | Current program counter |

## Verification
The bench builds the unit with its default widths: a 13-bit PC, an 8-bit low byte, an 11-bit jump immediate and an 8-bit latch. With these widths all 32 pages and the 0x1FFF→0 wrap are within reach of short directed sequences. Random strobe overlaps, each cycle checked against a bench model, cover every priority combination. They also cover the case where a latch write shares a cycle with a load that reads the latch.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
    typedef enum logic [2:0] {
        SRC_HOLD = 3'd0,
        SRC_INC  = 3'd1,
        SRC_LOW  = 3'd2,
        SRC_JUMP = 3'd3,
        SRC_RET  = 3'd4
    } src_e;
endpackage

// File: rtl/ppc_latch.sv
module ppc_latch #(
    parameter int LATCH_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [LATCH_W-1:0] wdata,
    output logic [LATCH_W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else if (wr) q <= wdata;
    end

    // R7: the latch changes only through its own write port
    a_r7_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> q == $past(q));
    a_r7_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> q == $past(wdata));
endmodule

// File: rtl/ppc_src_arb.sv
module ppc_src_arb
    import ppc_pkg::*;
(
    input  logic ret_en,
    input  logic jump_en,
    input  logic low_wr,
    input  logic inc_en,
    output src_e src
);
    // R6: fixed priority order
    always_comb begin
        if (ret_en)       src = SRC_RET;
        else if (jump_en) src = SRC_JUMP;
        else if (low_wr)  src = SRC_LOW;
        else if (inc_en)  src = SRC_INC;
        else              src = SRC_HOLD;
    end
endmodule

// File: rtl/ppc_next.sv
module ppc_next
    import ppc_pkg::*;
#(
    parameter int PC_W    = 13,
    parameter int LOW_W   = 8,
    parameter int IMM_W   = 11,
    parameter int LATCH_W = 8
) (
    input  src_e               src,
    input  logic [PC_W-1:0]    pc_q,
    input  logic [LATCH_W-1:0] latch,
    input  logic [LOW_W-1:0]   low_wdata,
    input  logic [IMM_W-1:0]   jump_target,
    input  logic [PC_W-1:0]    ret_addr,
    output logic [PC_W-1:0]    pc_d
);
    localparam int HI_W   = PC_W - LOW_W;
    localparam int PAGE_W = PC_W - IMM_W;
    localparam int PAGE_H = PC_W - 1 - LOW_W;

    logic [HI_W-1:0]   hi_from_latch;
    logic [PAGE_W-1:0] page_from_latch;

    assign hi_from_latch   = latch[HI_W-1:0];
    assign page_from_latch = latch[PAGE_H -: PAGE_W];

    always_comb begin
        unique case (src)
            SRC_RET:  pc_d = ret_addr;
            SRC_JUMP: pc_d = {page_from_latch, jump_target};
            SRC_LOW:  pc_d = {hi_from_latch, low_wdata};
            SRC_INC:  pc_d = pc_q + PC_W'(1);
            SRC_HOLD: pc_d = pc_q;
            default:  pc_d = pc_q;
        endcase
    end
endmodule

// File: rtl/paged_pc.sv
module paged_pc
    import ppc_pkg::*;
#(
    parameter int PC_W    = 13,
    parameter int LOW_W   = 8,
    parameter int IMM_W   = 11,
    parameter int LATCH_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               inc_en,
    input  logic               low_wr,
    input  logic [LOW_W-1:0]   low_wdata,
    input  logic               latch_wr,
    input  logic [LATCH_W-1:0] latch_wdata,
    output logic [LATCH_W-1:0] latch_rdata,
    input  logic               jump_en,
    input  logic [IMM_W-1:0]   jump_target,
    input  logic               ret_en,
    input  logic [PC_W-1:0]    ret_addr,
    output logic [PC_W-1:0]    pc_out
);
    localparam int HI_W   = PC_W - LOW_W;
    localparam int PAGE_W = PC_W - IMM_W;
    localparam int PAGE_H = PC_W - 1 - LOW_W;

    src_e            src;
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_d;

    ppc_latch #(.LATCH_W(LATCH_W)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (latch_wr),
        .wdata (latch_wdata),
        .q     (latch_rdata)
    );

    ppc_src_arb u_arb (
        .ret_en  (ret_en),
        .jump_en (jump_en),
        .low_wr  (low_wr),
        .inc_en  (inc_en),
        .src     (src)
    );

    ppc_next #(
        .PC_W(PC_W), .LOW_W(LOW_W), .IMM_W(IMM_W), .LATCH_W(LATCH_W)
    ) u_next (
        .src         (src),
        .pc_q        (pc_q),
        .latch       (latch_rdata),
        .low_wdata   (low_wdata),
        .jump_target (jump_target),
        .ret_addr    (ret_addr),
        .pc_d        (pc_d)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    // output process
    always_comb pc_out = pc_q;

    // R1
    a_r1_reset_zero: assert property (@(posedge clk) !rst_n |-> pc_out == '0);
    // R5 / R6
    a_r5_ret_load: assert property (@(posedge clk) disable iff (!rst_n)
        ret_en |=> pc_out == $past(ret_addr));
    // R4 / R8
    a_r4_jump_page: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_en && !ret_en) |=>
        pc_out == {$past(latch_rdata[PAGE_H -: PAGE_W]), $past(jump_target)});
    // R3 / R8
    a_r3_low_write: assert property (@(posedge clk) disable iff (!rst_n)
        (low_wr && !jump_en && !ret_en) |=>
        pc_out == {$past(latch_rdata[HI_W-1:0]), $past(low_wdata)});
    // R2
    a_r2_inc_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_en && !low_wr && !jump_en && !ret_en) |=>
        pc_out == PC_W'($past(pc_out) + PC_W'(1)));
    // R9
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_en && !low_wr && !jump_en && !ret_en) |=> $stable(pc_out));
endmodule

// File: tb/test_paged_pc.sv
`timescale 1ns/1ps
module test_paged_pc;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        inc_en, low_wr, latch_wr, jump_en, ret_en;
    logic [7:0]  low_wdata, latch_wdata, latch_rdata;
    logic [10:0] jump_target;
    logic [12:0] ret_addr, pc_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [12:0] m_pc;
    logic [7:0]  m_lat;

    always #10 clk = ~clk;

    paged_pc i_paged_pc (
        .clk(clk), .rst_n(rst_n), .inc_en(inc_en), .low_wr(low_wr),
        .low_wdata(low_wdata), .latch_wr(latch_wr), .latch_wdata(latch_wdata),
        .latch_rdata(latch_rdata), .jump_en(jump_en), .jump_target(jump_target),
        .ret_en(ret_en), .ret_addr(ret_addr), .pc_out(pc_out)
    );

    function automatic logic [12:0] model_pc(logic [12:0] pc, logic [7:0] lat);
        if (ret_en)       return ret_addr;
        else if (jump_en) return {lat[4:3], jump_target};
        else if (low_wr)  return {lat[4:0], low_wdata};
        else if (inc_en)  return pc + 13'd1;
        else              return pc;
    endfunction

    function automatic string tag_of();
        int n = int'(ret_en) + int'(jump_en) + int'(low_wr) + int'(inc_en);
        string t;
        if (ret_en)       t = "R5";
        else if (jump_en) t = "R4";
        else if (low_wr)  t = "R3";
        else if (inc_en)  t = "R2";
        else              t = "R9";
        if (n > 1) t = {"R6 ", t};
        if (latch_wr && (jump_en || low_wr) && !ret_en) t = {"R8 ", t};
        return t;
    endfunction

    task automatic chk(string tag, logic [12:0] got, logic [12:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic idle();
        inc_en = 0; low_wr = 0; latch_wr = 0; jump_en = 0; ret_en = 0;
        low_wdata = 0; latch_wdata = 0; jump_target = 0; ret_addr = 0;
    endtask

    // inputs already set; called at a negedge
    task automatic step();
        logic [12:0] e_pc;
        logic [7:0]  e_lat;
        string t;
        e_pc  = model_pc(m_pc, m_lat);
        e_lat = latch_wr ? latch_wdata : m_lat;
        t = tag_of();
        @(negedge clk);
        chk(t, pc_out, e_pc);
        chk("R7 latch", {5'd0, latch_rdata}, {5'd0, e_lat});
        m_pc = e_pc; m_lat = e_lat;
        idle();
    endtask

    initial begin
        idle();
        rst_n = 0;
        m_pc = 0; m_lat = 0;
        repeat (2) @(negedge clk);
        chk("R1 pc", pc_out, 13'd0);
        chk("R1 latch", {5'd0, latch_rdata}, 13'd0);
        rst_n = 1;
        step();                                      // R9 hold after reset
        latch_wr = 1; latch_wdata = 8'hE5; step();   // R7, bits 7:5 set
        low_wr = 1; low_wdata = 8'h10; step();       // R3: expect 0x0510
        chk("R3 direct", pc_out, 13'h0510);
        latch_wr = 1; latch_wdata = 8'h0A; step();
        low_wr = 1; low_wdata = 8'(8'hF0 + 8'h20); step(); // R3 no carry
        chk("R3 computed", pc_out, 13'h0A10);
        latch_wr = 1; latch_wdata = 8'h18; step();
        jump_en = 1; jump_target = 11'h123; step();  // R4
        chk("R4 direct", pc_out, 13'h1923);
        ret_en = 1; ret_addr = 13'h1FFF; step();     // R5
        inc_en = 1; step();                          // R2 wrap
        chk("R2 wrap", pc_out, 13'h0000);
        ret_en = 1; ret_addr = 13'h0ABC; jump_en = 1; low_wr = 1;
        inc_en = 1; step();                          // R6
        chk("R6 ret wins", pc_out, 13'h0ABC);
        jump_en = 1; jump_target = 11'h7FF; latch_wr = 1;
        latch_wdata = 8'h00; step();                 // R8: old page 11
        chk("R8 old latch", pc_out, 13'h1FFF);
        step();                                      // R9
        chk("R9 hold", pc_out, 13'h1FFF);
        void'($urandom(32'd4242));
        for (int i = 0; i < 3000; i++) begin
            inc_en   = ($urandom() % 2) == 0;
            low_wr   = ($urandom() % 4) == 0;
            latch_wr = ($urandom() % 4) == 0;
            jump_en  = ($urandom() % 5) == 0;
            ret_en   = ($urandom() % 6) == 0;
            low_wdata   = 8'($urandom());
            latch_wdata = 8'($urandom());
            jump_target = 11'($urandom());
            ret_addr    = 13'($urandom());
            step();
        end
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule